// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of translation entries from memory. A request carries the virtual address, the kind of access (read, write or instruction fetch) and whether the requester runs in user or supervisor mode. The walker combines the root pointer with the top ten address bits to find the directory entry. That entry's frame number and the next ten address bits locate the table entry. The frame number in the table entry is then joined with the untranslated 12-bit page offset.

Both entries are checked for presence, write permission and user access. A failing check ends the walk with a fault and a cause code. A passing walk sets the accessed flag of each entry it walks. A write also sets the dirty flag of the final entry. These flag updates are written back to memory before the response is returned, and only when the stored word actually changes. The walker handles a single translation at a time. It talks to memory through a valid/ready request channel and a read-response channel. Writes get no response.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is high, and mem_req_valid and rsp_valid are low.
- R2: The directory entry is read from ptbr + VA[31:22]*4. The table entry is read after it from {directory entry[31:12], 12'h000} + VA[21:12]*4.
- R3: A walk with no fault returns rsp_fault=0, rsp_cause=0 and rsp_paddr = {table entry[31:12], VA[11:0]}.
- R4: An entry with bit 0 (present) clear faults with cause 1. If the directory entry is absent, the table entry is never read.
- R5: When req_user=1, an entry at either level with bit 2 (user) clear faults with cause 3. When req_user=0, bit 2 is ignored.
- R6: A write (req_acc=2'b01) to an entry at either level with bit 1 (writable) clear faults with cause 2, in either mode. A read (2'b00) or a fetch (2'b10) never raises this fault.
- R7: Within one entry, the checks rank as absent first, then privilege, then write protection. The directory entry is judged before the table entry.
- R8: Each entry that passes its checks gets bit 5 (accessed) set in memory. The table entry also gets bit 6 (dirty) set on a write. The directory entry never gets bit 6 set.
- R9: An entry is written back only if its value changes. An entry that faults is never written.
- R10: Only one walk is in flight. req_ready is low from acceptance until the response. rsp_valid lasts one cycle.
- R11: While mem_req_valid is high and mem_req_ready is low, the address, write flag and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 treated as read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| ptbr | input | 32 | Physical address of the directory |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Entry address |
| mem_req_wdata | output | 32 | Updated entry for write-back |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Translation result valid, one cycle |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 2 | 0 none, 1 absent, 2 write-protect, 3 privilege |
| rsp_paddr | output | 32 | Physical address, zero on a fault |

## Verification
The hardest situation to reach is one where a write-back is held off by memory backpressure while read responses arrive late. This is where a changing address or a dropped flag update would show. The bench memory model drives mem_req_ready from a pseudo-random sequence and adds a programmable read latency. It runs the same mappings again with both enabled. The bench also prepares entries whose flags are already set, so it can tell a skipped write-back from a missing one. It sets conflicting permission bits on a single entry to exercise the fault ranking.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int PRESENT_BIT = 0;
  localparam int WRITE_BIT   = 1;
  localparam int USER_BIT    = 2;
  localparam int ACC_BIT     = 5;
  localparam int DIRTY_BIT   = 6;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_WPROT  = 2'd2,
    CAUSE_PRIV   = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DRD,
    S_DWAIT,
    S_DWB,
    S_TRD,
    S_TWAIT,
    S_TWB,
    S_RESP
  } walk_state_e;
endpackage

// File: rtl/pt_rst_sync.sv
module pt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int PA_W  = 32,
  parameter int IDX_W = 10
) (
  input  logic [PA_W-1:0]  base,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  addr
);
  localparam int PAD_W = PA_W - IDX_W - 2;

  assign addr = base + {{PAD_W{1'b0}}, idx, 2'b00};
endmodule

// File: rtl/pt_level_check.sv
module pt_level_check
  import pt_walker_pkg::*;
#(
  parameter int ENT_W = 32,
  parameter bit LEAF  = 1'b0
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             is_write,
  input  logic             is_user,
  output cause_e           cause,
  output logic             need_wb,
  output logic [ENT_W-1:0] wb_entry
);
  logic [ENT_W-1:0] set_mask;

  generate
    if (LEAF) begin : g_leaf
      always_comb begin
        set_mask            = '0;
        set_mask[ACC_BIT]   = 1'b1;
        set_mask[DIRTY_BIT] = is_write;
      end
    end else begin : g_dir
      always_comb begin
        set_mask          = '0;
        set_mask[ACC_BIT] = 1'b1;
      end
    end
  endgenerate

  // ranking: absent, then privilege, then write protection
  always_comb begin
    if (!entry[PRESENT_BIT])                cause = CAUSE_ABSENT;
    else if (is_user && !entry[USER_BIT])   cause = CAUSE_PRIV;
    else if (is_write && !entry[WRITE_BIT]) cause = CAUSE_WPROT;
    else                                    cause = CAUSE_NONE;
  end

  assign wb_entry = entry | set_mask;
  assign need_wb  = (cause == CAUSE_NONE) && (wb_entry != entry);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [1:0]      req_acc,
  input  logic            req_user,
  input  logic [PA_W-1:0] ptbr,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_we,
  output logic [PA_W-1:0] mem_req_addr,
  output logic [PA_W-1:0] mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [PA_W-1:0] mem_rsp_rdata,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic [1:0]      rsp_cause,
  output logic [PA_W-1:0] rsp_paddr
);
  localparam int IDX_W   = (VA_W - OFF_W) / 2;
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int KEEP_W  = VA_W - IDX_W;

  logic rst_n_s;

  pt_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  walk_state_e state_q, state_d;
  logic [KEEP_W-1:0] vaddr_q;
  logic              wr_q;
  logic              user_q;
  logic [PA_W-1:0]   dir_addr_q;
  logic [PA_W-1:0]   tbl_addr_q;
  logic [PA_W-1:0]   wdata_q;
  logic [PA_W-1:0]   paddr_q;
  logic              fault_q;
  cause_e            cause_q;

  logic ld_req, ld_dir, ld_tbl;
  logic req_is_write;

  // entry address: directory from the root, table from the returned frame
  logic [PA_W-1:0]  ea_base;
  logic [IDX_W-1:0] ea_idx;
  logic [PA_W-1:0]  ea_addr;

  always_comb begin
    if (state_q == S_IDLE) begin
      ea_base = ptbr;
      ea_idx  = req_vaddr[VA_W-1 -: IDX_W];
    end else begin
      ea_base = {mem_rsp_rdata[PA_W-1:OFF_W], {OFF_W{1'b0}}};
      ea_idx  = vaddr_q[OFF_W +: IDX_W];
    end
  end

  pt_entry_addr #(.PA_W(PA_W), .IDX_W(IDX_W)) u_entry_addr (
    .base (ea_base),
    .idx  (ea_idx),
    .addr (ea_addr)
  );

  cause_e          dir_cause, tbl_cause;
  logic            dir_need, tbl_need;
  logic [PA_W-1:0] dir_wb, tbl_wb;

  pt_level_check #(.ENT_W(PA_W), .LEAF(1'b0)) u_dir_check (
    .entry    (mem_rsp_rdata),
    .is_write (wr_q),
    .is_user  (user_q),
    .cause    (dir_cause),
    .need_wb  (dir_need),
    .wb_entry (dir_wb)
  );

  pt_level_check #(.ENT_W(PA_W), .LEAF(1'b1)) u_tbl_check (
    .entry    (mem_rsp_rdata),
    .is_write (wr_q),
    .is_user  (user_q),
    .cause    (tbl_cause),
    .need_wb  (tbl_need),
    .wb_entry (tbl_wb)
  );

  assign req_is_write = (req_acc == ACC_WRITE);
  assign ld_req = (state_q == S_IDLE)  && req_valid;
  assign ld_dir = (state_q == S_DWAIT) && mem_rsp_valid;
  assign ld_tbl = (state_q == S_TWAIT) && mem_rsp_valid;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (req_valid) state_d = S_DRD;
      S_DRD:   if (mem_req_ready) state_d = S_DWAIT;
      S_DWAIT: if (mem_rsp_valid) begin
                 if (dir_cause != CAUSE_NONE) state_d = S_RESP;
                 else if (dir_need)           state_d = S_DWB;
                 else                         state_d = S_TRD;
               end
      S_DWB:   if (mem_req_ready) state_d = S_TRD;
      S_TRD:   if (mem_req_ready) state_d = S_TWAIT;
      S_TWAIT: if (mem_rsp_valid) begin
                 if (tbl_cause != CAUSE_NONE) state_d = S_RESP;
                 else if (tbl_need)           state_d = S_TWB;
                 else                         state_d = S_RESP;
               end
      S_TWB:   if (mem_req_ready) state_d = S_RESP;
      S_RESP:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) state_q <= S_IDLE;
    else          state_q <= state_d;
  end

  // data registers, loaded by explicit enables
  always_ff @(posedge clk) begin
    if (ld_req) begin
      vaddr_q    <= req_vaddr[KEEP_W-1:0];
      wr_q       <= req_is_write;
      user_q     <= req_user;
      dir_addr_q <= ea_addr;
      fault_q    <= 1'b0;
      cause_q    <= CAUSE_NONE;
      paddr_q    <= '0;
    end
    if (ld_dir) begin
      tbl_addr_q <= ea_addr;
      wdata_q    <= dir_wb;
      if (dir_cause != CAUSE_NONE) begin
        fault_q <= 1'b1;
        cause_q <= dir_cause;
      end
    end
    if (ld_tbl) begin
      wdata_q <= tbl_wb;
      if (tbl_cause != CAUSE_NONE) begin
        fault_q <= 1'b1;
        cause_q <= tbl_cause;
      end else begin
        paddr_q <= {mem_rsp_rdata[PA_W-1 -: FRAME_W], vaddr_q[OFF_W-1:0]};
      end
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_DRD) || (state_q == S_DWB) ||
                         (state_q == S_TRD) || (state_q == S_TWB);
  assign mem_req_we    = (state_q == S_DWB) || (state_q == S_TWB);
  assign mem_req_addr  = ((state_q == S_DRD) || (state_q == S_DWB)) ? dir_addr_q : tbl_addr_q;
  assign mem_req_wdata = wdata_q;
  assign rsp_valid     = (state_q == S_RESP);
  assign rsp_fault     = fault_q;
  assign rsp_cause     = cause_q;
  assign rsp_paddr     = paddr_q;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_ready |-> !mem_req_valid && !rsp_valid);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_we) && $stable(mem_req_wdata));

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_valid |=> !rsp_valid && req_ready);

  // R10
  one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_valid && req_ready |=> !req_ready);

  // R3
  cause_match_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)));

  // R9
  wb_flags_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_req_valid && mem_req_we |-> mem_req_wdata[PRESENT_BIT] && mem_req_wdata[ACC_BIT]);
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [1:0]  req_acc;
  logic        req_user;
  logic [31:0] ptbr;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_req_we;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic [31:0] rsp_paddr;

  pt_walker u_dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_vaddr (req_vaddr),
    .req_acc (req_acc), .req_user (req_user), .ptbr (ptbr),
    .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
    .mem_req_we (mem_req_we), .mem_req_addr (mem_req_addr),
    .mem_req_wdata (mem_req_wdata), .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata), .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault), .rsp_cause (rsp_cause), .rsp_paddr (rsp_paddr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  bit [31:0] mem [bit [31:0]];
  bit [31:0] rd_log [$];
  int n_checks = 0;
  int n_fail   = 0;
  int rd_cnt, wr_cnt;
  int lat_cfg   = 0;
  int ready_mode = 0;
  bit [15:0] lfsr = 16'hACE1;
  bit mem_pend;
  int mem_wait;
  bit [31:0] mem_pend_data;
  bit busy;
  bit got_rsp, got_fault;
  bit [1:0]  got_cause;
  bit [31:0] got_paddr;
  bit stall_q;
  bit [31:0] stall_addr, stall_data;
  bit stall_we;
  bit done;

  function automatic bit [31:0] rd(input bit [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // memory model and per-clock monitor
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_pend) begin
        if (mem_wait == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = mem_pend_data;
          mem_pend = 1'b0;
        end else mem_wait--;
      end
      if (stall_q && rst_n)
        check(mem_req_valid && mem_req_addr == stall_addr && mem_req_we == stall_we &&
              mem_req_wdata == stall_data, "R11", "held request", mem_req_addr, stall_addr);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_req_ready = (ready_mode == 0) ? 1'b1 : lfsr[0];
      stall_q = rst_n && mem_req_valid && !mem_req_ready;
      stall_addr = mem_req_addr; stall_we = mem_req_we; stall_data = mem_req_wdata;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (!busy) check(1'b0, "R10", "memory access while idle", 1, 0);
        if (mem_req_we) begin
          mem[mem_req_addr] = mem_req_wdata;
          wr_cnt++;
        end else begin
          rd_cnt++;
          rd_log.push_back(mem_req_addr);
          mem_pend = 1'b1;
          mem_pend_data = rd(mem_req_addr);
          mem_wait = lat_cfg;
        end
      end
      if (rst_n && rsp_valid) begin
        if (!busy) check(1'b0, "R10", "response while idle", 1, 0);
        got_rsp = 1'b1; got_fault = rsp_fault; got_cause = rsp_cause; got_paddr = rsp_paddr;
      end
    end
  end

  task automatic walk(input bit [31:0] va, input bit [1:0] acc, input bit usr, input string tag);
    bit [31:0] da, ta, pde, pte, npde, npte, epaddr;
    bit [1:0] ca;
    int ereads, ewrites;
    bit wr = (acc == 2'b01);
    da = ptbr + {20'h0, va[31:22], 2'b00};
    pde = rd(da); npde = pde; ta = '0; pte = '0; npte = '0; epaddr = '0;
    ereads = 1; ewrites = 0; ca = 2'd0;
    if (!pde[0]) ca = 2'd1;
    else if (usr && !pde[2]) ca = 2'd3;
    else if (wr && !pde[1]) ca = 2'd2;
    if (ca == 0) begin
      npde = pde | 32'h20;
      if (npde != pde) ewrites++;
      ta = {pde[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
      pte = rd(ta); npte = pte; ereads = 2;
      if (!pte[0]) ca = 2'd1;
      else if (usr && !pte[2]) ca = 2'd3;
      else if (wr && !pte[1]) ca = 2'd2;
      if (ca == 0) begin
        npte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
        if (npte != pte) ewrites++;
        epaddr = {pte[31:12], va[11:0]};
      end
    end
    rd_log.delete(); rd_cnt = 0; wr_cnt = 0; got_rsp = 1'b0; busy = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_user = usr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R10", {tag, " ready after accept"}, req_ready, 0);
    for (int i = 0; i < 400 && !got_rsp; i++) begin
      @(negedge clk); #1;
    end
    check(got_rsp, "R10", {tag, " response arrived"}, got_rsp, 1);
    @(negedge clk); #1;
    check(!rsp_valid && req_ready, "R10", {tag, " single pulse"}, rsp_valid, 0);
    busy = 1'b0;
    check(got_cause == ca && got_fault == (ca != 0),
          (ca == 1) ? "R4" : (ca == 2) ? "R6" : (ca == 3) ? "R5" : "R3",
          {tag, " cause"}, got_cause, ca);
    if (ca == 0) check(got_paddr == epaddr, "R3", {tag, " paddr"}, got_paddr, epaddr);
    check(rd_cnt == ereads, "R4", {tag, " read count"}, rd_cnt, ereads);
    if (rd_log.size() > 0) check(rd_log[0] == da, "R2", {tag, " directory address"}, rd_log[0], da);
    if (ereads == 2 && rd_log.size() > 1)
      check(rd_log[1] == ta, "R2", {tag, " table address"}, rd_log[1], ta);
    check(wr_cnt == ewrites, "R9", {tag, " write-back count"}, wr_cnt, ewrites);
    check(rd(da) == npde, "R8", {tag, " directory entry"}, rd(da), npde);
    if (ereads == 2) check(rd(ta) == npte, "R8", {tag, " table entry"}, rd(ta), npte);
  endtask

  task automatic map(input bit [9:0] di, input bit [31:0] pde, input bit [9:0] ti, input bit [31:0] pte);
    mem[ptbr + {20'h0, di, 2'b00}] = pde;
    mem[{pde[31:12], 12'h0} + {20'h0, ti, 2'b00}] = pte;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_acc = '0; req_user = 1'b0;
    ptbr = 32'h0001_0000; busy = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(req_ready && !mem_req_valid && !rsp_valid, "R1", "reset state", req_ready, 1);

    // R3 R8 first walk sets accessed at both levels
    map(10'd1, 32'h0002_0007, 10'd1, 32'hABCD_E007);
    walk(32'h0040_1ABC, 2'b00, 1'b1, "R3 first read");
    // R9 flags already set: no write-back
    ready_mode = 1; lat_cfg = 2;
    walk(32'h0040_1123, 2'b00, 1'b1, "R9 repeat read");
    // R8 write sets dirty in the table entry only
    walk(32'h0040_1FFF, 2'b01, 1'b1, "R8 write dirty");
    walk(32'h0040_1000, 2'b01, 1'b0, "R9 repeat write");
    // R4 directory absent, table never read
    mem[ptbr + 32'd8] = 32'h0003_0006;
    walk(32'h0080_2004, 2'b10, 1'b0, "R4 dir absent");
    // R4 table absent with directory already accessed
    map(10'd3, 32'h0004_0027, 10'd3, 32'h0005_0000);
    walk(32'h00C0_3010, 2'b00, 1'b0, "R4 table absent");
    // R5 supervisor-only directory
    map(10'd4, 32'h0006_0003, 10'd4, 32'h0007_0007);
    walk(32'h0100_4321, 2'b00, 1'b1, "R5 user denied");
    walk(32'h0100_4321, 2'b00, 1'b0, "R5 kernel allowed");
    // R6 read-only table entry
    map(10'd5, 32'h0008_0007, 10'd5, 32'h0009_0005);
    walk(32'h0140_5008, 2'b01, 1'b1, "R6 user write denied");
    walk(32'h0140_5008, 2'b01, 1'b0, "R6 kernel write denied");
    walk(32'h0140_5ABC, 2'b10, 1'b1, "R6 fetch allowed");
    walk(32'h0140_5ABC, 2'b00, 1'b1, "R6 read no dirty");
    // R7 privilege outranks write protection on one entry
    map(10'd6, 32'h000A_0001, 10'd6, 32'h000B_0007);
    walk(32'h0180_6000, 2'b01, 1'b1, "R7 priv over wprot");
    // R7 absent outranks privilege
    map(10'd7, 32'h000C_0007, 10'd7, 32'h000D_0002);
    walk(32'h01C0_7000, 2'b00, 1'b1, "R7 absent over priv");
    // R8 write on a fresh mapping: directory gets accessed only
    map(10'd8, 32'h000E_0003, 10'd9, 32'h000F_0003);
    walk(32'h0200_9777, 2'b01, 1'b0, "R8 fresh write");
    // R3 offsets pass through under varied latency and backpressure
    for (int k = 0; k < 6; k++) begin
      lat_cfg = k % 3; ready_mode = k % 2;
      walk({10'd1, 10'd1, 12'(k * 12'h2D3 + 1)}, 2'(k % 3), 1'(k % 2), "R3 offset sweep");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule